// File: doc/BRIEF.md
# Chained Auxiliary Up/Down Counter with Selectable Count Edge

The block holds a core timer, a one-bit toggle latch and an auxiliary counter. The core timer steps by one on each clock while its run enable is high, counting up or down. At its upper or lower limit it wraps, and the same step inverts the toggle latch. The auxiliary counter moves by one, up or down under its own direction input, whenever the selected count event occurs.

A three-bit mode input picks the event. Its top bit chooses the source: the external count pin, or the toggle latch. Its two low bits enable counting on rising edges, on falling edges, or on both. The external pin first passes through a synchroniser, and is then compared with its previous sample.

When the latch is the source, the core timer and the auxiliary counter form one chained counter. Counting on both latch edges advances the auxiliary counter on every core wrap. Counting on one edge advances it on every second wrap, so the latch bit becomes an extra middle stage. Software can load the core timer, the latch and the auxiliary counter directly. A latch load never counts as an event.

Top module: `aux_chain_counter`

## Requirements
- R1: After reset the core timer, the toggle latch and the auxiliary counter all read zero.
- R2: While coreRun is high and no core load occurs, the core timer steps by one each clock: up when coreDown is 0, down when it is 1. It wraps from all-ones to zero going up, and from zero to all-ones going down. A wrap inverts the toggle latch on the same clock edge.
- R3: When edgeMode[1:0] is 00 (mode 000 or 100), no event counts and the auxiliary counter holds its value.
- R4: edgeMode[2] = 0 selects the external pin. Bit 0 enables rising edges and bit 1 enables falling edges, so 001 = rising, 010 = falling, 011 = both. Each level of the pin must be held for at least two clocks. After the pin changes, the auxiliary counter moves on the third rising clock edge.
- R5: edgeMode[2] = 1 selects the toggle latch, with the same bit meaning: 101 counts wraps that set the latch to 1, 110 counts wraps that clear it to 0, and 111 counts every wrap.
- R6: With mode 111, the auxiliary counter advances once per core wrap, forming a double-width chain. With mode 101 or 110, it advances once per two core wraps, with the latch acting as an extra middle bit.
- R7: The auxiliary counter counts up when auxDown is 0 and down when it is 1, independent of coreDown. It wraps at its own limits.
- R8: A latch load (wrLatchEn) never produces a count event. When it coincides with a core wrap, the loaded value wins and the wrap does not count. A core load (wrCoreEn) takes priority over stepping, so no wrap occurs in that cycle.
- R9: An auxiliary load (wrAuxEn) takes priority over a count event in the same cycle.
- R10: Activity on the source that is not selected has no effect on the auxiliary counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| edgeMode | input | 3 | Count source and edge select |
| countIn | input | 1 | External count pin (asynchronous) |
| coreRun | input | 1 | Core timer step enable |
| coreDown | input | 1 | Core timer direction, 1 = down |
| auxDown | input | 1 | Auxiliary counter direction, 1 = down |
| wrCoreEn | input | 1 | Load core timer |
| wrCoreData | input | CORE_W | Core timer load value |
| wrLatchEn | input | 1 | Load toggle latch |
| wrLatchData | input | 1 | Toggle latch load value |
| wrAuxEn | input | 1 | Load auxiliary counter |
| wrAuxData | input | AUX_W | Auxiliary counter load value |
| coreValue | output | CORE_W | Core timer value |
| latchValue | output | 1 | Toggle latch value |
| auxValue | output | AUX_W | Auxiliary counter value |

## Verification
The bench builds the block with its default parameters: 16-bit core and auxiliary widths and a two-stage synchroniser. With these values, the three-clock latency of the external pin is checked at an exact cycle.

Core wraps are produced by loading the core timer at a limit and stepping once, so every latch mode and direction mix is covered in a few hundred cycles rather than 65536 per wrap. Loading the auxiliary counter at its limits also brings its own wrap within reach.

// File: rtl/auxcnt_pkg.sv
package auxcnt_pkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic coreLoad;
    logic coreStep;
    logic latchLoad;
    logic latchToggle;
    logic auxLoad;
    logic auxStep;
  } auxStrobes_t;
endpackage

// File: rtl/auxcnt_sync.sv
module auxcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/auxcnt_ctrl.sv
module auxcnt_ctrl
  import auxcnt_pkg::*;
#(
  parameter int CORE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        edgeMode,
  input  logic              countIn,
  input  logic              coreRun,
  input  logic              coreDown,
  input  logic              wrCoreEn,
  input  logic              wrLatchEn,
  input  logic              wrAuxEn,
  input  logic [CORE_W-1:0] coreValue,
  input  logic              latchValue,
  output auxStrobes_t       strobes
);
  localparam logic [CORE_W-1:0] CORE_TOP = '1;
  localparam logic [CORE_W-1:0] CORE_BOT = '0;

  logic syncIn, prevIn;
  logic extRise, extFall;
  logic stepCore, atLimit, wrapPulse;
  logic latchRise, latchFall;
  logic srcRise, srcFall, countEvent;

  auxcnt_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (countIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= syncIn;
  end

  assign extRise = syncIn & ~prevIn;
  assign extFall = ~syncIn & prevIn;

  // Core wrap detection
  assign stepCore  = coreRun & ~wrCoreEn;
  assign atLimit   = coreDown ? (coreValue == CORE_BOT) : (coreValue == CORE_TOP);
  assign wrapPulse = stepCore & atLimit;

  // Latch events come from the wrap pulse and the latch's next value.
  // A software load of the latch never creates one.
  assign latchRise = wrapPulse & ~wrLatchEn & ~latchValue;
  assign latchFall = wrapPulse & ~wrLatchEn &  latchValue;

  assign srcRise    = edgeMode[2] ? latchRise : extRise;
  assign srcFall    = edgeMode[2] ? latchFall : extFall;
  assign countEvent = (edgeMode[0] & srcRise) | (edgeMode[1] & srcFall);

  always_comb begin
    strobes             = '0;
    strobes.coreLoad    = wrCoreEn;
    strobes.coreStep    = stepCore;
    strobes.latchLoad   = wrLatchEn;
    strobes.latchToggle = wrapPulse & ~wrLatchEn;
    strobes.auxLoad     = wrAuxEn;
    strobes.auxStep     = countEvent & ~wrAuxEn;
  end
endmodule

// File: rtl/auxcnt_datapath.sv
module auxcnt_datapath
  import auxcnt_pkg::*;
#(
  parameter int CORE_W = 16,
  parameter int AUX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobes_t       strobes,
  input  logic              coreDown,
  input  logic              auxDown,
  input  logic [CORE_W-1:0] wrCoreData,
  input  logic              wrLatchData,
  input  logic [AUX_W-1:0]  wrAuxData,
  output logic [CORE_W-1:0] coreValue,
  output logic              latchValue,
  output logic [AUX_W-1:0]  auxValue
);
  localparam logic [CORE_W-1:0] CORE_ONE = CORE_W'(1);
  localparam logic [AUX_W-1:0]  AUX_ONE  = AUX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 coreValue <= '0;
    else if (strobes.coreLoad) coreValue <= wrCoreData;
    else if (strobes.coreStep) coreValue <= coreDown ? coreValue - CORE_ONE
                                                     : coreValue + CORE_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    latchValue <= 1'b0;
    else if (strobes.latchLoad)   latchValue <= wrLatchData;
    else if (strobes.latchToggle) latchValue <= ~latchValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                auxValue <= '0;
    else if (strobes.auxLoad) auxValue <= wrAuxData;
    else if (strobes.auxStep) auxValue <= auxDown ? auxValue - AUX_ONE
                                                  : auxValue + AUX_ONE;
  end
endmodule

// File: rtl/aux_chain_counter.sv
module aux_chain_counter
  import auxcnt_pkg::*;
#(
  parameter int CORE_W      = 16,
  parameter int AUX_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        edgeMode,
  input  logic              countIn,
  input  logic              coreRun,
  input  logic              coreDown,
  input  logic              auxDown,
  input  logic              wrCoreEn,
  input  logic [CORE_W-1:0] wrCoreData,
  input  logic              wrLatchEn,
  input  logic              wrLatchData,
  input  logic              wrAuxEn,
  input  logic [AUX_W-1:0]  wrAuxData,
  output logic [CORE_W-1:0] coreValue,
  output logic              latchValue,
  output logic [AUX_W-1:0]  auxValue
);
  auxStrobes_t strobes;

  auxcnt_ctrl #(.CORE_W(CORE_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .edgeMode   (edgeMode),
    .countIn    (countIn),
    .coreRun    (coreRun),
    .coreDown   (coreDown),
    .wrCoreEn   (wrCoreEn),
    .wrLatchEn  (wrLatchEn),
    .wrAuxEn    (wrAuxEn),
    .coreValue  (coreValue),
    .latchValue (latchValue),
    .strobes    (strobes)
  );

  auxcnt_datapath #(.CORE_W(CORE_W), .AUX_W(AUX_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .coreDown    (coreDown),
    .auxDown     (auxDown),
    .wrCoreData  (wrCoreData),
    .wrLatchData (wrLatchData),
    .wrAuxData   (wrAuxData),
    .coreValue   (coreValue),
    .latchValue  (latchValue),
    .auxValue    (auxValue)
  );
endmodule

// File: rtl/auxcnt_checker.sv
module auxcnt_checker #(
  parameter int CORE_W = 16,
  parameter int AUX_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        edgeMode,
  input logic              coreRun,
  input logic              coreDown,
  input logic              wrCoreEn,
  input logic              wrLatchEn,
  input logic              wrAuxEn,
  input logic [AUX_W-1:0]  wrAuxData,
  input logic [CORE_W-1:0] coreValue,
  input logic              latchValue,
  input logic [AUX_W-1:0]  auxValue
);
  localparam logic [CORE_W-1:0] C_TOP = '1;
  localparam logic [CORE_W-1:0] C_BOT = '0;
  localparam logic [AUX_W-1:0]  A_ONE = AUX_W'(1);

  p_core_up_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun && !wrCoreEn && !coreDown && coreValue == C_TOP) |=> (coreValue == C_BOT));

  p_core_down_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun && !wrCoreEn && coreDown && coreValue == C_BOT) |=> (coreValue == C_TOP));

  p_wrap_toggles_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun && !wrCoreEn && !wrLatchEn &&
     ((coreDown && coreValue == C_BOT) || (!coreDown && coreValue == C_TOP)))
    |=> (latchValue != $past(latchValue)));

  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMode[1:0] == 2'b00 && !wrAuxEn) |=> (auxValue == $past(auxValue)));

  p_unit_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrAuxEn |=> (auxValue == $past(auxValue) || auxValue == $past(auxValue) + A_ONE ||
                  auxValue == $past(auxValue) - A_ONE));

  p_latch_load_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrLatchEn && !wrAuxEn && edgeMode[2]) |=> (auxValue == $past(auxValue)));

  p_latch_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLatchEn && !(coreRun && !wrCoreEn)) |=> $stable(latchValue));

  p_aux_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrAuxEn |=> (auxValue == $past(wrAuxData)));
endmodule

bind aux_chain_counter auxcnt_checker #(.CORE_W(CORE_W), .AUX_W(AUX_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .edgeMode   (edgeMode),
  .coreRun    (coreRun),
  .coreDown   (coreDown),
  .wrCoreEn   (wrCoreEn),
  .wrLatchEn  (wrLatchEn),
  .wrAuxEn    (wrAuxEn),
  .wrAuxData  (wrAuxData),
  .coreValue  (coreValue),
  .latchValue (latchValue),
  .auxValue   (auxValue)
);

// File: tb/aux_chain_counter_test.sv
`timescale 1ns/1ps
module aux_chain_counter_test;
  localparam int CORE_W = 16;
  localparam int AUX_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        edgeMode = 3'b000;
  logic              countIn = 1'b0;
  logic              coreRun = 1'b0;
  logic              coreDown = 1'b0;
  logic              auxDown = 1'b0;
  logic              wrCoreEn = 1'b0;
  logic [CORE_W-1:0] wrCoreData = '0;
  logic              wrLatchEn = 1'b0;
  logic              wrLatchData = 1'b0;
  logic              wrAuxEn = 1'b0;
  logic [AUX_W-1:0]  wrAuxData = '0;
  logic [CORE_W-1:0] coreValue;
  logic              latchValue;
  logic [AUX_W-1:0]  auxValue;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  aux_chain_counter #(.CORE_W(CORE_W), .AUX_W(AUX_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .edgeMode(edgeMode), .countIn(countIn),
    .coreRun(coreRun), .coreDown(coreDown), .auxDown(auxDown),
    .wrCoreEn(wrCoreEn), .wrCoreData(wrCoreData),
    .wrLatchEn(wrLatchEn), .wrLatchData(wrLatchData),
    .wrAuxEn(wrAuxEn), .wrAuxData(wrAuxData),
    .coreValue(coreValue), .latchValue(latchValue), .auxValue(auxValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAux(input logic [AUX_W-1:0] v);
    wrAuxEn = 1'b1; wrAuxData = v; tick(1); wrAuxEn = 1'b0;
  endtask

  task automatic setLatch(input logic v);
    wrLatchEn = 1'b1; wrLatchData = v; tick(1); wrLatchEn = 1'b0;
  endtask

  task automatic setCore(input logic [CORE_W-1:0] v);
    wrCoreEn = 1'b1; wrCoreData = v; tick(1); wrCoreEn = 1'b0;
  endtask

  task automatic wrapOnce(input logic down);
    coreDown = down;
    setCore(down ? '0 : '1);
    coreRun = 1'b1; tick(1); coreRun = 1'b0;
  endtask

  task automatic extPulse();
    countIn = 1'b1; tick(4); countIn = 1'b0; tick(4);
  endtask

  task automatic testReset();
    chk("R1 core", 32'(coreValue), 0);
    chk("R1 latch", 32'(latchValue), 0);
    chk("R1 aux", 32'(auxValue), 0);
  endtask

  task automatic testCoreWrap();
    edgeMode = 3'b000;
    coreDown = 1'b0; setLatch(1'b0); setCore(16'hFFFE);
    coreRun = 1'b1; tick(1);
    chk("R2 up step", 32'(coreValue), 32'hFFFF);
    chk("R2 no toggle before wrap", 32'(latchValue), 0);
    tick(1);
    chk("R2 up wrap", 32'(coreValue), 0);
    chk("R2 latch toggle up", 32'(latchValue), 1);
    coreRun = 1'b0;
    coreDown = 1'b1; setCore(16'h0001);
    coreRun = 1'b1; tick(2); coreRun = 1'b0;
    chk("R2 down wrap", 32'(coreValue), 32'hFFFF);
    chk("R2 latch toggle down", 32'(latchValue), 0);
    coreDown = 1'b0;
  endtask

  task automatic testDisabled();
    edgeMode = 3'b000; setAux(16'd7);
    extPulse(); wrapOnce(1'b0);
    chk("R3 mode 000 holds", 32'(auxValue), 7);
    edgeMode = 3'b100;
    extPulse(); wrapOnce(1'b0); wrapOnce(1'b0);
    chk("R3 mode 100 holds", 32'(auxValue), 7);
  endtask

  task automatic testExtEdges();
    auxDown = 1'b0;
    edgeMode = 3'b001; setAux('0);
    for (int i = 0; i < 3; i++) extPulse();
    chk("R4 rising count", 32'(auxValue), 3);
    edgeMode = 3'b010; setAux('0);
    for (int i = 0; i < 3; i++) extPulse();
    chk("R4 falling count", 32'(auxValue), 3);
    edgeMode = 3'b011; setAux('0);
    for (int i = 0; i < 3; i++) extPulse();
    chk("R4 both edges count", 32'(auxValue), 6);
    auxDown = 1'b1; setAux(16'd10);
    for (int i = 0; i < 2; i++) extPulse();
    chk("R7 ext count down", 32'(auxValue), 6);
    auxDown = 1'b0;
  endtask

  task automatic testExtLatency();
    edgeMode = 3'b001; setAux('0);
    countIn = 1'b1; tick(2);
    chk("R4 not yet after two edges", 32'(auxValue), 0);
    tick(1);
    chk("R4 counted on third edge", 32'(auxValue), 1);
    countIn = 1'b0; tick(4);
    chk("R4 falling ignored in 001", 32'(auxValue), 1);
  endtask

  task automatic testLatchModes();
    auxDown = 1'b0;
    edgeMode = 3'b111; setLatch(1'b0); setAux('0);
    for (int i = 0; i < 4; i++) wrapOnce(1'b0);
    chk("R6 both edges every wrap", 32'(auxValue), 4);
    chk("R6 latch after four wraps", 32'(latchValue), 0);
    edgeMode = 3'b101; setLatch(1'b0); setAux('0);
    wrapOnce(1'b0);
    chk("R5 rising latch counts", 32'(auxValue), 1);
    wrapOnce(1'b0);
    chk("R5 falling latch ignored in 101", 32'(auxValue), 1);
    wrapOnce(1'b0); wrapOnce(1'b0);
    chk("R6 single edge every second wrap", 32'(auxValue), 2);
    edgeMode = 3'b110; setLatch(1'b0); setAux('0);
    wrapOnce(1'b0);
    chk("R5 rising latch ignored in 110", 32'(auxValue), 0);
    wrapOnce(1'b0);
    chk("R5 falling latch counts", 32'(auxValue), 1);
    edgeMode = 3'b111; setAux('0);
    wrapOnce(1'b1); wrapOnce(1'b1);
    chk("R6 underflow wraps chain", 32'(auxValue), 2);
  endtask

  task automatic testOpposite();
    edgeMode = 3'b111;
    auxDown = 1'b1; setAux(16'd5);
    wrapOnce(1'b0); wrapOnce(1'b0);
    chk("R7 core up aux down", 32'(auxValue), 3);
    auxDown = 1'b0; setAux(16'hFFFF);
    wrapOnce(1'b1);
    chk("R7 core down aux up wraps", 32'(auxValue), 0);
  endtask

  task automatic testLatchWrite();
    edgeMode = 3'b111; setAux(16'd9);
    setLatch(1'b1); setLatch(1'b0); setLatch(1'b1);
    chk("R8 latch load no count", 32'(auxValue), 9);
    chk("R8 latch loaded", 32'(latchValue), 1);
    setLatch(1'b0);
    coreDown = 1'b0; setCore('1);
    coreRun = 1'b1; wrLatchEn = 1'b1; wrLatchData = 1'b1; tick(1);
    coreRun = 1'b0; wrLatchEn = 1'b0;
    chk("R8 load beats wrap latch", 32'(latchValue), 1);
    chk("R8 load with wrap no count", 32'(auxValue), 9);
    chk("R8 core still wrapped", 32'(coreValue), 0);
    setCore('1);
    coreRun = 1'b1; wrCoreEn = 1'b1; wrCoreData = 16'h0100; tick(1);
    coreRun = 1'b0; wrCoreEn = 1'b0;
    chk("R8 core load beats step", 32'(coreValue), 32'h0100);
    chk("R8 no wrap on core load", 32'(latchValue), 1);
    chk("R8 no count on core load", 32'(auxValue), 9);
  endtask

  task automatic testAuxPriority();
    edgeMode = 3'b111; setLatch(1'b0); setAux('0);
    coreDown = 1'b0; setCore('1);
    coreRun = 1'b1; wrAuxEn = 1'b1; wrAuxData = 16'h1234; tick(1);
    coreRun = 1'b0; wrAuxEn = 1'b0;
    chk("R9 aux load beats event", 32'(auxValue), 32'h1234);
    chk("R9 latch still toggled", 32'(latchValue), 1);
  endtask

  task automatic testSourceIsolation();
    edgeMode = 3'b111; setAux(16'd3);
    extPulse(); extPulse();
    chk("R10 pin ignored in latch mode", 32'(auxValue), 3);
    edgeMode = 3'b011; setAux(16'd3);
    wrapOnce(1'b0); wrapOnce(1'b0);
    chk("R10 wraps ignored in pin mode", 32'(auxValue), 3);
  endtask

  initial begin
    #(200000 * 8);
    failCount++; checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testCoreWrap();
    testDisabled();
    testExtEdges();
    testExtLatency();
    testLatchModes();
    testOpposite();
    testLatchWrite();
    testAuxPriority();
    testSourceIsolation();
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule